// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Memory for a 16-bit Bus

This block holds a 16-bit-wide data memory as two separate byte-wide banks. The even bank stores every byte whose address has bit 0 clear, and the odd bank stores every byte whose address has bit 0 set. A host drives a byte address, an active-low high-lane enable, a write enable and a 16-bit write bus. The upper address bits, from bit 1 up, form one location index that goes to both banks at once. Address bit 0 and the high-lane enable together pick the banks that take part in the access.

The even bank is tied to bus bits 7:0 and the odd bank to bus bits 15:8, whatever the access size. That gives aligned word, even byte and odd byte transfers without any byte swapping. A misaligned word has to be split into two transfers by the host. Reads are synchronous with one cycle of latency. Every access, write or read, returns the contents that the enabled lanes held before the access.

Top module: `dual_bank_mem`

## Requirements
- R1: Bytes with address bit 0 = 0 are stored in the even bank, and bytes with bit 0 = 1 in the odd bank. Both banks use address bits ADDR_W-1:1 as the shared location index, so an even byte and the odd byte above it share one index.
- R2: With address bit 0 = 0 and hi_en_n = 0 the access is a word access. A write stores wdata[7:0] in the even bank and wdata[15:8] in the odd bank. A read returns the even byte on rdata[7:0] and the odd byte on rdata[15:8].
- R3: With address bit 0 = 0 and hi_en_n = 1 the access is an even byte access. A write updates only the even bank, from wdata[7:0], and the odd bank keeps its contents. The returned rdata[15:8] is 0.
- R4: With address bit 0 = 1 and hi_en_n = 0 the access is an odd byte access. A write updates only the odd bank, from wdata[15:8], and the even bank keeps its contents. The returned rdata[7:0] is 0.
- R5: With address bit 0 = 1 and hi_en_n = 1 no bank is selected. A write changes no stored byte. The returned rdata is 0, and err is 1 if the access was a read.
- R6: rdata and err for an access sampled at a rising edge (req = 1) appear after that edge and are valid until the next accepted access.
- R7: A write returns, on the enabled lanes, the data that location held before the write (read-before-write).
- R8: rdata and err hold their values across cycles with req = 0.
- R9: Synchronous reset drives rdata to 0 and err to 0.
- R10: err is 0 after any access that selects at least one bank, and after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled at the rising edge |
| addr | input | ADDR_W | Byte address; bit 0 selects the even/odd lane |
| hi_en_n | input | 1 | Active-low enable of the odd (high) bank |
| wr_en | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data; bits 7:0 go to the even bank, bits 15:8 to the odd bank |
| rdata | output | 16 | Returned data, one cycle after the request |
| err | output | 1 | Read with no bank selected |

## Verification
Word writes first fill every index with lane values that are computed from the index, so each even byte differs from its odd neighbour. Then even-only and odd-only writes go over that contents, and the readback shows whether a byte write leaked into the neighbouring bank or was dropped. All four combinations of bit 0 and the high-lane enable are swept over every index, with reads and with writes. The swept reads tell apart the zeroing of the disabled lane, the read-before-write return and the no-bank case, where a write must change nothing. Idle cycles and a reset in the middle of the run show that the outputs hold and clear as required.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    localparam int LANE_W  = 8;
    localparam int N_LANES = 2;
    localparam int BUS_W   = LANE_W * N_LANES;

    typedef enum logic [1:0] {
        XFER_NONE    = 2'd0,
        XFER_EVEN_B  = 2'd1,
        XFER_ODD_B   = 2'd2,
        XFER_WORD    = 2'd3
    } xfer_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } lane_sel_t;

    function automatic xfer_e classify(input logic a0, input logic hi_en_n);
        xfer_e k;
        case ({a0, hi_en_n})
            2'b00:   k = XFER_WORD;
            2'b01:   k = XFER_EVEN_B;
            2'b10:   k = XFER_ODD_B;
            default: k = XFER_NONE;
        endcase
        return k;
    endfunction

    function automatic lane_sel_t lanes_of(input xfer_e k);
        lane_sel_t s;
        s.lo = (k == XFER_WORD) || (k == XFER_EVEN_B);
        s.hi = (k == XFER_WORD) || (k == XFER_ODD_B);
        return s;
    endfunction

endpackage

// File: rtl/dbm_decode.sv
module dbm_decode
    import dbm_pkg::*;
(
    input  logic      req,
    input  logic      a0,
    input  logic      hi_en_n,
    input  logic      wr_en,
    output lane_sel_t sel,
    output logic      wr_go,
    output logic      bad_rd
);
    xfer_e     kind;
    lane_sel_t raw;

    always_comb begin
        kind   = classify(a0, hi_en_n);
        raw    = lanes_of(kind);
        sel.lo = req & raw.lo;
        sel.hi = req & raw.hi;
        wr_go  = req & wr_en;
        bad_rd = req & ~wr_en & (kind == XFER_NONE);
    end
endmodule

// File: rtl/dbm_bank.sv
module dbm_bank #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdat,
    output logic [WIDTH-1:0] rdat
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Read-before-write: the registered output takes the old cell value.
    always_ff @(posedge clk) begin
        if (en) begin
            rdat <= cells[idx];
            if (we) begin
                cells[idx] <= wdat;
            end
        end
    end
endmodule

// File: rtl/dbm_steer.sv
module dbm_steer
    import dbm_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req,
    input  lane_sel_t                      sel,
    input  logic                           bad_rd,
    input  logic [N_LANES-1:0][LANE_W-1:0] bank_rd,
    output logic [BUS_W-1:0]               rdata,
    output logic                           err
);
    lane_sel_t sel_q;
    logic      err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            err_q <= 1'b0;
        end else if (req) begin
            sel_q <= sel;
            err_q <= bad_rd;
        end
    end

    always_comb begin
        rdata[LANE_W-1:0]     = sel_q.lo ? bank_rd[0] : '0;
        rdata[BUS_W-1:LANE_W] = sel_q.hi ? bank_rd[1] : '0;
        err                   = err_q;
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(rdata) && $stable(err)));

endmodule

// File: rtl/dual_bank_mem.sv
module dual_bank_mem
    import dbm_pkg::*;
#(
    parameter int ADDR_W = 11,
    localparam int IDX_W = ADDR_W - 1,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hi_en_n,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              err
);
    lane_sel_t                      sel;
    logic                           wr_go;
    logic                           bad_rd;
    logic [N_LANES-1:0]             lane_en;
    logic [N_LANES-1:0][LANE_W-1:0] lane_wd;
    logic [N_LANES-1:0][LANE_W-1:0] lane_rd;
    logic [IDX_W-1:0]               idx;

    assign idx     = addr[ADDR_W-1:1];
    assign lane_en = {sel.hi, sel.lo};
    assign lane_wd = wdata;

    dbm_decode u_dec (
        .req     (req),
        .a0      (addr[0]),
        .hi_en_n (hi_en_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_go   (wr_go),
        .bad_rd  (bad_rd)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        dbm_bank #(.DEPTH(DEPTH), .WIDTH(LANE_W)) u_bank (
            .clk  (clk),
            .en   (lane_en[g]),
            .we   (wr_go),
            .idx  (idx),
            .wdat (lane_wd[g]),
            .rdat (lane_rd[g])
        );
    end

    dbm_steer u_steer (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .sel     (sel),
        .bad_rd  (bad_rd),
        .bank_rd (lane_rd),
        .rdata   (rdata),
        .err     (err)
    );

    // R3
    even_byte_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !addr[0] && hi_en_n) |=> (rdata[15:8] == '0));

    // R4
    odd_byte_lo_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req && addr[0] && !hi_en_n) |=> (rdata[7:0] == '0));

    // R5
    no_bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req && addr[0] && hi_en_n) |=> (rdata == '0 && err == !$past(wr_en)));

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req && (wr_en || !addr[0] || !hi_en_n)) |=> !err);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rdata == '0 && !err));

endmodule

// File: tb/dual_bank_mem_test.sv
`timescale 1ns/1ps
module dual_bank_mem_test;
    localparam int AW  = 6;
    localparam int NB  = 1 << AW;
    localparam int NIX = NB / 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          req;
    logic [AW-1:0] addr;
    logic          hi_en_n;
    logic          wr_en;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
    logic          err;

    int n_vec  = 0;
    int n_fail = 0;
    logic [7:0] mdl [NB];

    always #2 clk = ~clk;

    dual_bank_mem #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .hi_en_n(hi_en_n),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .err(err)
    );

    task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access: drive at negedge, sampled at posedge, result checked at the
    // next negedge (R6: one register on the read path).
    task automatic access(input int a, input logic hn, input logic we, input logic [15:0] wd);
        logic       lo_on;
        logic       hi_on;
        logic [15:0] exp;
        logic       exp_err;
        string      tag;
        int         base;
        base    = a & ~1;
        lo_on   = ((a & 1) == 0);
        hi_on   = !hn;
        exp     = {hi_on ? mdl[base+1] : 8'h00, lo_on ? mdl[base] : 8'h00};
        exp_err = !we && !lo_on && !hi_on;
        if (lo_on && hi_on)      tag = "R2 word";
        else if (lo_on)          tag = "R3 even byte";
        else if (hi_on)          tag = "R4 odd byte";
        else                     tag = "R5 no bank";
        if (we) tag = {tag, " R7 write-return"};
        else    tag = {tag, " R1 R6 read"};
        @(negedge clk);
        req = 1'b1; addr = AW'(a); hi_en_n = hn; wr_en = we; wdata = wd;
        @(posedge clk);
        if (we && lo_on) mdl[base]   = wd[7:0];
        if (we && hi_on) mdl[base+1] = wd[15:8];
        @(negedge clk);
        req = 1'b0;
        chk(tag, {err, rdata}, {exp_err, exp});
        if (!exp_err) chk("R10 err low", {16'h0, err}, 17'h0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : stim
        logic [15:0] held;
        logic        held_e;
        rst = 1'b1; req = 1'b0; addr = '0; hi_en_n = 1'b1; wr_en = 1'b0; wdata = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 reset", {err, rdata}, 17'h0);
        rst = 1'b0;

        // Fill with word writes; first pass returns unknown old data, so
        // fill the model by a silent pass and check from the second pass on.
        for (int i = 0; i < NIX; i++) begin
            @(negedge clk);
            req = 1'b1; addr = AW'(2*i); hi_en_n = 1'b0; wr_en = 1'b1;
            wdata = {8'(i*13 + 8'h5A), 8'(i*7 + 3)};
            @(posedge clk);
            mdl[2*i]   = 8'(i*7 + 3);
            mdl[2*i+1] = 8'(i*13 + 8'h5A);
        end
        @(negedge clk) req = 1'b0;

        // All four lane combinations, reads, over every index
        for (int i = 0; i < NIX; i++)
            for (int c = 0; c < 4; c++)
                access(2*i + (c & 1), c[1], 1'b0, 16'h0);

        // Byte writes on either lane, then word readback (R1, R3, R4)
        for (int i = 0; i < NIX; i++) begin
            access(2*i,   1'b1, 1'b1, {8'hEE, 8'(8'hC0 ^ i)});
            access(2*i+1, 1'b0, 1'b1, {8'(8'h30 + 3*i), 8'h11});
            access(2*i,   1'b0, 1'b0, 16'h0);
        end

        // No-bank writes must change nothing (R5), then word rewrite
        for (int i = 0; i < NIX; i++) begin
            access(2*i+1, 1'b1, 1'b1, 16'hFFFF);
            access(2*i,   1'b0, 1'b0, 16'h0);
            access(2*i,   1'b0, 1'b1, {8'(~i), 8'(i*5)});
            access(2*i,   1'b0, 1'b0, 16'h0);
        end

        // R8: hold across idle cycles after a no-bank read and after a word read
        access(3, 1'b1, 1'b0, 16'h0);
        held = rdata; held_e = err;
        repeat (3) @(negedge clk);
        chk("R8 hold after no-bank read", {err, rdata}, {held_e, held});
        access(6, 1'b0, 1'b0, 16'h0);
        held = rdata; held_e = err;
        repeat (4) @(negedge clk);
        chk("R8 hold after word read", {err, rdata}, {held_e, held});

        // R9: reset in the middle of the run
        access(9, 1'b1, 1'b0, 16'h0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 mid-run reset", {err, rdata}, 17'h0);
        rst = 1'b0;
        access(8, 1'b0, 1'b0, 16'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule